// File: doc/BRIEF.md
# Delta Modulation Output Unit

This block turns a stream of buffered sample bytes into a 7-bit audio level for a downstream mixer. Each byte is played one bit at a time, least significant bit first, with one bit per pulse of an external rate tick. A 1 bit raises the level by two and a 0 bit lowers it by two. The level is clamped so that it never leaves the 7-bit range. Every byte is played over an output cycle of exactly eight ticks, and nothing cuts a cycle short.

When an output cycle ends, the unit looks at the one-byte sample buffer in front of it. If the buffer holds a byte, the unit takes it into its shift register and pulses a consume strobe so that the memory side knows the buffer is now empty. If the buffer is empty, the next eight ticks are silent and the level holds. Software can also overwrite the level at any time through a direct-load strobe. That write leaves the byte in progress, its remaining bit count and the silence state untouched.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the unit leaves reset two clock edges after the input goes high.

Top module: `dmo_output_unit`

## Requirements
- R1: After reset, level_o is 0 and consume_o is 0. The first output cycle is silent and lasts eight ticks.
- R2: On the clock in which tick_i ends a cycle and buf_full_i is 1, consume_o is 1. The buffer byte then becomes the next cycle's bits and silence is cleared.
- R3: If buf_full_i is 0 at the end of a cycle, consume_o stays 0 and level_o does not change through the eight ticks of the next cycle unless a direct load occurs.
- R4: A tick that plays a 1 bit (silence clear) raises level_o by 2 on the next clock when the level is below 126, and leaves it unchanged when the level is 126 or 127.
- R5: A tick that plays a 0 bit (silence clear) lowers level_o by 2 on the next clock when the level is above 1, and leaves it unchanged when the level is 0 or 1.
- R6: Bits play least significant bit first, one per tick. level_o changes only on the clock after a tick or a direct load.
- R7: Every output cycle is exactly eight ticks long. consume_o is 1 only on the eighth tick of a cycle, even if the buffer fills earlier.
- R8: load_i = 1 makes level_o equal load_val_i on the next clock. A direct load wins over a tick in the same clock.
- R9: A direct load does not change the remaining bits of the current byte, the tick count of the cycle or the silence state.
- R10: consume_o is 1 only on clocks where tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| tick_i | input | 1 | Rate tick, one bit played per pulse |
| buf_full_i | input | 1 | Sample buffer holds a byte |
| buf_data_i | input | 8 | Sample buffer byte |
| load_i | input | 1 | Direct-load strobe for the level |
| load_val_i | input | 7 | Value written by a direct load |
| consume_o | output | 1 | Buffer byte taken this clock; buffer becomes empty |
| level_o | output | 7 | Current 7-bit output level |

## Verification
The embedded assertions check, on every clock, the ±2 step and the clamps at both ends, that the level holds without a tick or load, that a direct load lands one clock later, that a taken byte's bit 0 appears and silence clears, that an empty buffer at a boundary sets silence, and that the bit count stays in range. Only the bench scenarios can show properties that span a whole cycle: the least-significant-first order across a byte, that a buffer filling mid-cycle waits for the eighth tick, and that a load mid-byte lets the rest of the byte continue. The bench's reference model follows the byte queue through gapped ticks, back-to-back ticks, a load and a tick in the same clock, and the saturation at both ends.

// File: rtl/dmo_pkg.sv
package dmo_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/dmo_rst_sync.sv
module dmo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dmo_shifter.sv
module dmo_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              buf_full_i,
  input  logic [BYTE_W-1:0] buf_data_i,
  output logic              consume_o,
  output logic              silent_o,
  output logic              bit_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              silent_q, silent_d;
  logic              last_bit, boundary;

  assign last_bit  = (cnt_q == CNT_ONE);
  assign boundary  = tick_i & last_bit;
  assign consume_o = boundary & buf_full_i;

  always_comb begin
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    silent_d = silent_q;
    if (tick_i) begin
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - CNT_ONE;
      if (last_bit) begin
        cnt_d    = CNT_FULL;
        silent_d = ~buf_full_i;
        if (buf_full_i) sh_d = buf_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= CNT_FULL;
      silent_q <= 1'b1;
    end else if (tick_i) begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      silent_q <= silent_d;
    end
  end

  assign silent_o = silent_q;
  assign bit_o    = sh_q[0];

  // R2: a taken byte starts playing with its bit 0 and silence cleared
  p_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    consume_o |=> (!silent_o && (bit_o == $past(buf_data_i[0]))));
  // R3: an empty buffer at the boundary makes the next cycle silent
  p_empty_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !buf_full_i) |=> silent_o);
  // R7: the bit count never leaves 1..BYTE_W
  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CNT_FULL));
  // R9: without a tick the byte and silence state hold
  p_hold_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(sh_q) && $stable(silent_q) && $stable(cnt_q)));
endmodule

// File: rtl/dmo_level.sv
module dmo_level
  import dmo_pkg::*;
#(
  parameter int unsigned LVL_W = 7,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             silent_i,
  input  logic             bit_i,
  input  logic             load_i,
  input  logic [LVL_W-1:0] load_val_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] HI_LIM = LVL_W'((1 << LVL_W) - STEP);
  localparam logic [LVL_W-1:0] LO_LIM = LVL_W'(STEP - 1);
  localparam logic [LVL_W-1:0] STEP_V = LVL_W'(STEP);

  logic [LVL_W-1:0] level_q, level_d;
  logic             level_en, may_move;
  step_dir_e        dir;

  always_comb begin
    dir      = bit_i ? DIR_UP : DIR_DOWN;
    may_move = (dir == DIR_UP) ? (level_q < HI_LIM) : (level_q > LO_LIM);
    level_en = load_i | (tick_i & ~silent_i & may_move);
    if (load_i)              level_d = load_val_i;
    else if (dir == DIR_UP)  level_d = level_q + STEP_V;
    else                     level_d = level_q - STEP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= '0;
    else if (level_en) level_q <= level_d;
  end

  assign level_o = level_q;

  // R4: step up below the ceiling
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && !silent_i && bit_i && (level_q < HI_LIM))
      |=> (level_o == $past(level_q) + STEP_V));
  // R4: saturate at the ceiling
  p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && !silent_i && bit_i && (level_q >= HI_LIM)) |=> $stable(level_o));
  // R5: step down above the floor
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && !silent_i && !bit_i && (level_q > LO_LIM))
      |=> (level_o == $past(level_q) - STEP_V));
  // R5: saturate at the floor
  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && !silent_i && !bit_i && (level_q <= LO_LIM)) |=> $stable(level_o));
  // R6: no change without a tick or a load
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(level_o));
  // R8: direct load lands next clock, ahead of any tick
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (level_o == $past(load_val_i)));
endmodule

// File: rtl/dmo_output_unit.sv
module dmo_output_unit #(
  parameter int unsigned LVL_W       = 7,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned STEP        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              buf_full_i,
  input  logic [BYTE_W-1:0] buf_data_i,
  input  logic              load_i,
  input  logic [LVL_W-1:0]  load_val_i,
  output logic              consume_o,
  output logic [LVL_W-1:0]  level_o
);
  logic rst_sync_n;
  logic silent;
  logic play_bit;

  dmo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dmo_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .buf_full_i (buf_full_i),
    .buf_data_i (buf_data_i),
    .consume_o  (consume_o),
    .silent_o   (silent),
    .bit_o      (play_bit)
  );

  dmo_level #(.LVL_W(LVL_W), .STEP(STEP)) u_level (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .silent_i   (silent),
    .bit_i      (play_bit),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .level_o    (level_o)
  );

  // R10: a consume strobe only accompanies a tick, checked one clock later
  p_consume_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    consume_o |=> $past(tick_i));
endmodule

// File: tb/dmo_output_unit_tb.sv
module dmo_output_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       buf_full_i = 1'b0;
  logic [7:0] buf_data_i = '0;
  logic       load_i = 1'b0;
  logic [6:0] load_val_i = '0;
  logic       consume_o;
  logic [6:0] level_o;

  always #5 clk = ~clk;

  dmo_output_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .buf_full_i(buf_full_i),
    .buf_data_i(buf_data_i), .load_i(load_i), .load_val_i(load_val_i),
    .consume_o(consume_o), .level_o(level_o)
  );

  int     vectors = 0;
  int     errors = 0;
  string  cur_req = "R1";
  int     mdl_level = 0;
  int     mdl_left = 8;
  bit     mdl_silent = 1'b1;
  bit     bits_q[$];
  int     mem_q[$];
  bit     finished = 1'b0;

  task automatic compare(bit exp_cons);
    vectors++;
    if (level_o !== 7'(mdl_level)) begin
      errors++;
      $display("FAIL %s level_o actual=%0d expected=%0d", cur_req, level_o, mdl_level);
    end
    if (consume_o !== exp_cons) begin
      errors++;
      $display("FAIL %s consume_o actual=%0b expected=%0b", cur_req, consume_o, exp_cons);
    end
  endtask

  task automatic cyc(bit t, bit lv, int lval);
    bit exp_cons;
    bit b;
    @(negedge clk);
    tick_i     = t;
    load_i     = lv;
    load_val_i = 7'(lval);
    buf_full_i = (mem_q.size() > 0);
    buf_data_i = (mem_q.size() > 0) ? 8'(mem_q[0]) : 8'h00;
    #1;
    exp_cons = t && (mdl_left == 1) && (mem_q.size() > 0);
    compare(exp_cons);
    @(posedge clk);
    if (lv) mdl_level = lval;
    else if (t && !mdl_silent) begin
      b = bits_q[0];
      if (b && mdl_level < 126) mdl_level += 2;
      else if (!b && mdl_level > 1) mdl_level -= 2;
    end
    if (t) begin
      if (bits_q.size() > 0) void'(bits_q.pop_front());
      mdl_left--;
      if (mdl_left == 0) begin
        mdl_left = 8;
        bits_q.delete();
        if (mem_q.size() > 0) begin
          int v = mem_q.pop_front();
          for (int i = 0; i < 8; i++) bits_q.push_back(v[i]);
          mdl_silent = 1'b0;
        end else mdl_silent = 1'b1;
      end
    end
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 0);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 0);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; compare(1'b0);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 0);
    // R1: first cycle silent even with a full buffer; consume on 8th tick (R7)
    mem_q.push_back(8'hFF);
    ticks(8, 1);
    // R4: rising steps
    cur_req = "R4";
    mem_q.push_back(8'hFF);
    ticks(8, 1);
    cur_req = "R8";
    cyc(1'b0, 1'b1, 120);
    cur_req = "R4";
    mem_q.push_back(8'h00);
    mem_q.push_back(8'h00);
    ticks(8, 0);
    // R5: falling steps and floor
    cur_req = "R5";
    ticks(8, 1);
    cyc(1'b0, 1'b1, 3);
    ticks(8, 0);
    // R3: empty buffer at boundary -> silent cycle; R7: mid-cycle fill waits
    cur_req = "R3";
    cyc(1'b0, 1'b1, 50);
    ticks(4, 1);
    cur_req = "R7";
    mem_q.push_back(8'hA5);
    ticks(4, 1);
    // R6: LSB-first with idle gaps
    cur_req = "R6";
    mem_q.push_back(8'h3C);
    ticks(8, 2);
    // R9 / R8: load mid-byte, then load together with a tick
    cur_req = "R9";
    ticks(2, 0);
    cyc(1'b0, 1'b1, 64);
    ticks(1, 1);
    cur_req = "R8";
    cyc(1'b1, 1'b1, 100);
    cur_req = "R9";
    ticks(4, 1);
    // R2 / R10: back-to-back ticks with continuous refills
    cur_req = "R2";
    mem_q.push_back(8'h0F);
    mem_q.push_back(8'hF0);
    mem_q.push_back(8'h55);
    ticks(24, 0);
    cur_req = "R10";
    mem_q.push_back(8'hC3);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 0);
    // mixed pattern
    cur_req = "R6";
    lfsr = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      if (mem_q.size() == 0 && lfsr[3]) mem_q.push_back(lfsr[15:8]);
      cyc(lfsr[0], (lfsr[7:4] == 4'h9), lfsr[14:8]);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule